// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Core

This block is a watchdog counter with two timeout stages. Once enabled it counts down a first-stage interval taken from a 20-bit preload. When that interval runs out, it issues a warning pulse of a selectable kind and starts a second interval from a second preload. If software does not send a keep-alive before the second interval also runs out, the block either requests a system reset or, depending on its controls, restarts or parks. A sticky flag records that the watchdog caused a reset.

Time is measured in base ticks, which arrive as a one-cycle strobe. Each preload is multiplied by a power of two before counting: 2^15 in the slow mode (the default, `fast_clk_i` low) and 2^5 in the fast mode. The register decode that would feed these controls from a bus sits outside the block, so every control is a plain input.

The control sequencer is a four-state machine:
- IDLE: stopped, stage output 0.
- STAGE1: counting the first interval.
- STAGE2: counting the second interval.
- HOLD: the second interval expired with reset and free-run both off; stopped, stage output 1.

Its transitions are:
- ARM: IDLE to STAGE1 on a rising edge of enable.
- WARN: STAGE1 to STAGE2 on expiry.
- KICK: STAGE1, STAGE2 or HOLD to STAGE1 on keep-alive.
- BITE: STAGE2 to IDLE on expiry with reset enabled.
- CYCLE: STAGE2 to STAGE1 on expiry with free-run on and reset disabled.
- PARK: STAGE2 to HOLD on expiry with both off.
- STOP: any state to IDLE while enable is low.

STOP has priority over KICK, and KICK has priority over expiry.

Top module: `wdog_two_stage`

## Requirements
- R1: After `rst_n` is released, and before any enable edge, `irq_o`, `smi_o`, `rst_req_o`, `stage_o` and `prev_rst_o` are all 0.
- R2: A rising edge of `enable_i` loads the stage-1 count. With `fast_clk_i` high, the stage-1 expiry happens on the (preload1 × 32)-th tick after the load cycle.
- R3: With `fast_clk_i` low, the scale factor is 2^15, so a preload of 1 expires on the 32768th tick after the load cycle.
- R4: The counter advances only in cycles where `tick_i` is high. With `tick_i` held low, no expiry occurs.
- R5: At stage-1 expiry, `stage_o` becomes 1. The warning output depends on `int_type_i`: code 2'b00 gives a one-cycle `irq_o`, code 2'b10 gives a one-cycle `smi_o`, and codes 2'b01 and 2'b11 give no pulse. At most one of `irq_o`, `smi_o` and `rst_req_o` is high in any cycle.
- R6: The stage-2 interval lasts preload2 × 2^shift ticks, counted from the stage-1 expiry.
- R7: Stage-2 expiry with `reset_en_i` high gives a one-cycle `rst_req_o`, sets `prev_rst_o`, and returns the core to IDLE with `stage_o` 0. The core then does not restart until `enable_i` falls and rises again.
- R8: `prev_rst_o` stays set once set, and is cleared only by `rst_n`.
- R9: Stage-2 expiry with `reset_en_i` low and `free_run_i` high restarts stage 1 from preload1, with no `rst_req_o`.
- R10: Stage-2 expiry with `reset_en_i` and `free_run_i` both low parks the core. `stage_o` stays 1, the count stops, and no further pulse appears.
- R11: A `kick_i` pulse while enabled reloads preload1 and sets `stage_o` to 0, from stage 1, stage 2 or the parked state.
- R12: While `enable_i` is low, the core is stopped with `stage_o` 0, and `kick_i` has no effect.
- R13: A preload of 0 expires on the first tick after it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset, also clears the reset-history flag |
| tick_i | input | 1 | One-cycle base tick strobe |
| enable_i | input | 1 | Watchdog enable; its rising edge arms stage 1 |
| free_run_i | input | 1 | Restart stage 1 after stage-2 expiry when reset is disabled |
| fast_clk_i | input | 1 | 1: scale preloads by 2^5; 0: scale by 2^15 |
| int_type_i | input | 2 | Warning kind at stage-1 expiry (00 irq, 10 smi, others none) |
| reset_en_i | input | 1 | Request reset on stage-2 expiry |
| preload1_i | input | 20 | Stage-1 interval in scaled units |
| preload2_i | input | 20 | Stage-2 interval in scaled units |
| kick_i | input | 1 | Keep-alive pulse |
| irq_o | output | 1 | One-cycle warning interrupt pulse |
| smi_o | output | 1 | One-cycle system-management warning pulse |
| rst_req_o | output | 1 | One-cycle reset request pulse |
| stage_o | output | 1 | 0: stage 1 or idle; 1: stage 2 or parked |
| prev_rst_o | output | 1 | Sticky flag: the watchdog has requested a reset |

## Verification
Several properties are checked on every cycle:
- the pulses are mutually exclusive and each lasts one cycle;
- a warning pulse always coincides with stage 2;
- a reset request coincides with the flag set and stage 0;
- the flag never falls while out of reset;
- a low enable always forces stage 0 on the next cycle;
- a stopped counter holds its value.

Only the bench scenarios can show the exact interval lengths in both scale modes, the reaction to each warning code, the free-run, park and keep-alive paths, and the absence of a restart after a watchdog reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STAGE1 = 2'd1,
        ST_STAGE2 = 2'd2,
        ST_HOLD   = 2'd3
    } wdog_state_e;

    localparam logic [1:0] WARN_IRQ = 2'b00;
    localparam logic [1:0] WARN_SMI = 2'b10;

endpackage

// File: rtl/wdog_load_sel.sv
module wdog_load_sel #(
    parameter int PRELOAD_W  = 20,
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5,
    localparam int CNT_W     = PRELOAD_W + SLOW_SHIFT
) (
    input  logic                 sel_stage2_i,
    input  logic                 fast_i,
    input  logic [PRELOAD_W-1:0] preload1_i,
    input  logic [PRELOAD_W-1:0] preload2_i,
    output logic [CNT_W-1:0]     load_val_o
);

    logic [PRELOAD_W-1:0] chosen;
    logic [CNT_W-1:0]     widened;

    always_comb begin
        chosen  = sel_stage2_i ? preload2_i : preload1_i;
        widened = CNT_W'(chosen);
        if (fast_i) begin
            load_val_o = widened << FAST_SHIFT;
        end else begin
            load_val_o = widened << SLOW_SHIFT;
        end
    end

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int CNT_W = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] remain;

    // Expire on the tick that would take the remaining count to zero,
    // or at once when a zero count was loaded.
    assign expire_o = run_i && tick_i && (remain <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load_i) begin
            remain <= load_val_i;
        end else if (run_i && tick_i && !expire_o) begin
            remain <= remain - CNT_W'(1);
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        remain != '1); // R2

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(remain)); // R10

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       kick_i,
    input  logic       expire_i,
    input  logic [1:0] int_type_i,
    input  logic       reset_en_i,
    input  logic       free_run_i,
    output logic       load_o,
    output logic       sel_stage2_o,
    output logic       run_o,
    output logic       irq_o,
    output logic       smi_o,
    output logic       rst_req_o,
    output logic       stage_o,
    output logic       prev_rst_o
);

    wdog_state_e state_q, state_d;
    logic        en_q;
    logic        en_rise;
    logic        warn_ev;
    logic        bite_ev;

    assign en_rise = enable_i && !en_q;
    assign run_o   = (state_q == ST_STAGE1) || (state_q == ST_STAGE2);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= enable_i;
        end
    end

    // Transitions: STOP > KICK > expiry
    always_comb begin
        state_d      = state_q;
        load_o       = 1'b0;
        sel_stage2_o = 1'b0;
        warn_ev      = 1'b0;
        bite_ev      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en_rise) begin
                    state_d = ST_STAGE1;
                    load_o  = 1'b1;
                end
            end
            ST_STAGE1: begin
                if (!enable_i) begin
                    state_d = ST_IDLE;
                end else if (kick_i) begin
                    load_o = 1'b1;
                end else if (expire_i) begin
                    state_d      = ST_STAGE2;
                    load_o       = 1'b1;
                    sel_stage2_o = 1'b1;
                    warn_ev      = 1'b1;
                end
            end
            ST_STAGE2: begin
                if (!enable_i) begin
                    state_d = ST_IDLE;
                end else if (kick_i) begin
                    state_d = ST_STAGE1;
                    load_o  = 1'b1;
                end else if (expire_i) begin
                    if (reset_en_i) begin
                        state_d = ST_IDLE;
                        bite_ev = 1'b1;
                    end else if (free_run_i) begin
                        state_d = ST_STAGE1;
                        load_o  = 1'b1;
                    end else begin
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (!enable_i) begin
                    state_d = ST_IDLE;
                end else if (kick_i) begin
                    state_d = ST_STAGE1;
                    load_o  = 1'b1;
                end
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o      <= 1'b0;
            smi_o      <= 1'b0;
            rst_req_o  <= 1'b0;
            stage_o    <= 1'b0;
            prev_rst_o <= 1'b0;
        end else begin
            irq_o      <= warn_ev && (int_type_i == WARN_IRQ);
            smi_o      <= warn_ev && (int_type_i == WARN_SMI);
            rst_req_o  <= bite_ev;
            stage_o    <= (state_d == ST_STAGE2) || (state_d == ST_HOLD);
            prev_rst_o <= prev_rst_o || bite_ev;
        end
    end

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, smi_o, rst_req_o})); // R5

    AST_WARN_IN_STAGE2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || smi_o) |-> stage_o); // R5

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R5

    AST_BITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (prev_rst_o && !stage_o)); // R7

    AST_BITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        prev_rst_o |=> prev_rst_o); // R8

    AST_DISABLED_STAGE0: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !stage_o); // R12

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
    parameter int PRELOAD_W  = 20,
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 enable_i,
    input  logic                 free_run_i,
    input  logic                 fast_clk_i,
    input  logic [1:0]           int_type_i,
    input  logic                 reset_en_i,
    input  logic [PRELOAD_W-1:0] preload1_i,
    input  logic [PRELOAD_W-1:0] preload2_i,
    input  logic                 kick_i,
    output logic                 irq_o,
    output logic                 smi_o,
    output logic                 rst_req_o,
    output logic                 stage_o,
    output logic                 prev_rst_o
);

    localparam int CNT_W = PRELOAD_W + SLOW_SHIFT;

    logic             load;
    logic             sel_stage2;
    logic             run;
    logic             expire;
    logic [CNT_W-1:0] load_val;

    wdog_load_sel #(
        .PRELOAD_W (PRELOAD_W),
        .SLOW_SHIFT(SLOW_SHIFT),
        .FAST_SHIFT(FAST_SHIFT)
    ) i_load_sel (
        .sel_stage2_i(sel_stage2),
        .fast_i      (fast_clk_i),
        .preload1_i  (preload1_i),
        .preload2_i  (preload2_i),
        .load_val_o  (load_val)
    );

    wdog_countdown #(
        .CNT_W(CNT_W)
    ) i_countdown (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .load_val_i(load_val),
        .run_i     (run),
        .tick_i    (tick_i),
        .expire_o  (expire)
    );

    wdog_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .kick_i      (kick_i),
        .expire_i    (expire),
        .int_type_i  (int_type_i),
        .reset_en_i  (reset_en_i),
        .free_run_i  (free_run_i),
        .load_o      (load),
        .sel_stage2_o(sel_stage2),
        .run_o       (run),
        .irq_o       (irq_o),
        .smi_o       (smi_o),
        .rst_req_o   (rst_req_o),
        .stage_o     (stage_o),
        .prev_rst_o  (prev_rst_o)
    );

endmodule

// File: tb/test_wdog_two_stage.sv
`timescale 1ns/1ps
module test_wdog_two_stage;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_i;
    logic        enable_i;
    logic        free_run_i;
    logic        fast_clk_i;
    logic [1:0]  int_type_i;
    logic        reset_en_i;
    logic [19:0] preload1_i;
    logic [19:0] preload2_i;
    logic        kick_i;
    logic        irq_o, smi_o, rst_req_o, stage_o, prev_rst_o;

    int n_checks = 0;
    int n_fail   = 0;
    int n_bites  = 0;
    int cyc_count = 0;

    always #5 clk = ~clk;

    wdog_two_stage i_wdog_two_stage (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .enable_i(enable_i),
        .free_run_i(free_run_i), .fast_clk_i(fast_clk_i), .int_type_i(int_type_i),
        .reset_en_i(reset_en_i), .preload1_i(preload1_i), .preload2_i(preload2_i),
        .kick_i(kick_i), .irq_o(irq_o), .smi_o(smi_o), .rst_req_o(rst_req_o),
        .stage_o(stage_o), .prev_rst_o(prev_rst_o)
    );

    always @(negedge clk) begin
        if (rst_req_o) n_bites++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // sel: 0 irq, 1 smi, 2 rst_req, 3 irq or smi, 4 stage_o high
    function automatic bit pick(input int sel);
        case (sel)
            0: return irq_o;
            1: return smi_o;
            2: return rst_req_o;
            3: return irq_o | smi_o;
            default: return stage_o;
        endcase
    endfunction

    task automatic wait_ev(input int sel, input int limit, output int cyc);
        cyc = -1;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk); #1;
            if (pick(sel)) begin
                cyc = i;
                break;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        #1;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_i = 1'b1; enable_i = 1'b0; free_run_i = 1'b0;
        fast_clk_i = 1'b1; int_type_i = 2'b00; reset_en_i = 1'b1;
        preload1_i = 20'd3; preload2_i = 20'd2; kick_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        n_bites = 0;
    endtask

    task automatic arm();
        @(negedge clk);
        enable_i = 1'b1;
    endtask

    task automatic kick();
        @(negedge clk);
        kick_i = 1'b1;
        @(posedge clk); #1;
        kick_i = 1'b0;
    endtask

    task automatic t_reset_state();
        apply_reset();
        idle(3);
        chk({irq_o, smi_o, rst_req_o, stage_o, prev_rst_o} == 5'b0, "R1 outputs",
            int'({irq_o, smi_o, rst_req_o, stage_o, prev_rst_o}), 0);
    endtask

    task automatic t_full_bite();
        int c;
        apply_reset();
        arm();
        wait_ev(0, 500, c);
        chk(c == 97, "R2 stage1 length", c, 97);
        chk(stage_o == 1'b1, "R5 stage after warn", stage_o, 1);
        @(posedge clk); #1;
        chk(irq_o == 1'b0, "R5 irq one cycle", irq_o, 0);
        wait_ev(2, 500, c);
        chk(c == 63, "R6 stage2 length", c, 63);
        chk(prev_rst_o == 1'b1 && stage_o == 1'b0, "R7 flag and idle",
            int'({prev_rst_o, stage_o}), 2);
        @(posedge clk); #1;
        chk(rst_req_o == 1'b0, "R7 rst_req one cycle", rst_req_o, 0);
        wait_ev(4, 300, c);
        chk(c == -1, "R7 no restart while enable held", c, -1);
        chk(prev_rst_o == 1'b1, "R8 flag sticky", prev_rst_o, 1);
        @(negedge clk); enable_i = 1'b0;
        arm();
        wait_ev(0, 500, c);
        chk(c == 97, "R7 restart after new enable edge", c, 97);
        apply_reset();
        idle(1);
        chk(prev_rst_o == 1'b0, "R8 cleared by rst_n", prev_rst_o, 0);
    endtask

    task automatic t_smi();
        int c;
        apply_reset();
        int_type_i = 2'b10; preload1_i = 20'd1;
        arm();
        wait_ev(3, 200, c);
        chk(c == 33, "R5 smi timing", c, 33);
        chk(smi_o == 1'b1 && irq_o == 1'b0, "R5 smi selected",
            int'({smi_o, irq_o}), 2);
    endtask

    task automatic t_no_warn(input logic [1:0] code);
        int c;
        apply_reset();
        int_type_i = code; preload1_i = 20'd1;
        arm();
        wait_ev(4, 200, c);
        chk(c == 33, "R5 silent code stage change", c, 33);
        chk(smi_o == 1'b0 && irq_o == 1'b0, "R5 silent code no pulse",
            int'({smi_o, irq_o}), 0);
    endtask

    task automatic t_slow();
        int c;
        apply_reset();
        fast_clk_i = 1'b0; preload1_i = 20'd1;
        arm();
        wait_ev(0, 40000, c);
        chk(c == 32769, "R3 slow scale", c, 32769);
    endtask

    task automatic t_tick_gate();
        int c;
        apply_reset();
        tick_i = 1'b0; preload1_i = 20'd0;
        arm();
        wait_ev(4, 200, c);
        chk(c == -1 && irq_o == 1'b0, "R4 no count without tick", c, -1);
        @(negedge clk); tick_i = 1'b1;
        wait_ev(0, 10, c);
        chk(c == 1, "R4 counts once tick returns", c, 1);
    endtask

    task automatic t_free_run();
        int c;
        apply_reset();
        reset_en_i = 1'b0; free_run_i = 1'b1; preload1_i = 20'd1; preload2_i = 20'd1;
        arm();
        wait_ev(0, 200, c);
        chk(c == 33, "R9 first warn", c, 33);
        wait_ev(0, 200, c);
        chk(c == 64, "R9 restart period", c, 64);
        chk(n_bites == 0 && prev_rst_o == 1'b0, "R9 no reset request", n_bites, 0);
    endtask

    task automatic t_park();
        int c;
        apply_reset();
        reset_en_i = 1'b0; preload1_i = 20'd1; preload2_i = 20'd1;
        arm();
        wait_ev(0, 200, c);
        chk(c == 33, "R10 warn", c, 33);
        wait_ev(3, 300, c);
        chk(c == -1 && stage_o == 1'b1 && n_bites == 0, "R10 parked", c, -1);
        kick();
        chk(stage_o == 1'b0, "R11 kick from parked", stage_o, 0);
        wait_ev(0, 200, c);
        chk(c == 32, "R11 reload after kick", c, 32);
    endtask

    task automatic t_kick_stage1();
        int c;
        apply_reset();
        preload1_i = 20'd2;
        arm();
        idle(40);
        kick();
        wait_ev(0, 200, c);
        chk(c == 64, "R11 kick in stage1 reloads", c, 64);
        kick();
        chk(stage_o == 1'b0, "R11 kick in stage2", stage_o, 0);
    endtask

    task automatic t_disabled();
        int c;
        apply_reset();
        preload1_i = 20'd0;
        kick();
        wait_ev(3, 100, c);
        chk(c == -1 && stage_o == 1'b0, "R12 kick ignored when disabled", c, -1);
        preload1_i = 20'd1;
        arm();
        idle(10);
        @(negedge clk); enable_i = 1'b0;
        wait_ev(3, 200, c);
        chk(c == -1 && stage_o == 1'b0, "R12 disable stops count", c, -1);
    endtask

    task automatic t_zero();
        int c;
        apply_reset();
        preload1_i = 20'd0;
        arm();
        wait_ev(0, 20, c);
        chk(c == 2, "R13 zero preload", c, 2);
    endtask

    always @(posedge clk) begin
        cyc_count++;
        if (cyc_count > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_count, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_i = 1'b0; enable_i = 1'b0; free_run_i = 1'b0;
        fast_clk_i = 1'b1; int_type_i = 2'b00; reset_en_i = 1'b1;
        preload1_i = '0; preload2_i = '0; kick_i = 1'b0;
        t_reset_state();
        t_full_bite();
        t_smi();
        t_no_warn(2'b11);
        t_no_warn(2'b01);
        t_slow();
        t_tick_gate();
        t_free_run();
        t_park();
        t_kick_stage1();
        t_disabled();
        t_zero();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule